// File: doc/BRIEF.md
# Serial Two-Wire Slave with Auto-Incrementing Register Pointer

This block is a two-wire serial (I2C) slave that gives a bus master access to a small byte-wide register array through an internal address pointer. SCL and SDA are oversampled by the system clock through a two-flop synchronizer. The slave drives SDA only through an open-drain enable: when the enable is high, the pad pulls the line low. The block detects START, repeated START and STOP. It answers one 7-bit address, given as a parameter.

The pointer is loaded in a write transfer. The first byte after a write header becomes the pointer, and each later byte is stored where the pointer points. The pointer then advances at the end of that byte's acknowledge clock. A master reads in one of two ways:
- **Combined format:** a write header and a pointer byte, then a repeated START and a read header.
- **Current address:** a read header alone, which starts at whatever value the pointer last held.

During reads the pointer advances only when the master acknowledges a byte, so a master NACK leaves the pointer on the last byte sent. A read-only debug port shows any location of the array without involving the bus.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, sda_oe is 0 and every array location reads 0x00 on the debug port.
- R2: An address byte whose upper seven bits equal SLAVE_ADDR is acknowledged: sda_oe is 1 during the ninth SCL clock. Bit 0 of the address byte is R/W, with 0 meaning write and 1 meaning read.
- R3: An address byte that does not match gets no acknowledge. The slave ignores the bus until the next START, so no data in that transfer reaches the array.
- R4: The first byte after a matching write header is acknowledged and loads the pointer with its low log2(DEPTH) bits. The word address is therefore taken modulo DEPTH, and DEPTH must be a power of two.
- R5: Each later byte of a write is acknowledged and stored at the pointer. The pointer increments at the SCL fall that ends that byte's acknowledge clock.
- R6: The pointer wraps from DEPTH-1 to 0, on writes and on reads.
- R7: A matching read header causes the slave to transmit the byte at the pointer, MSB first. Each bit is valid while SCL is high.
- R8: When the master acknowledges a read byte (SDA low on the ninth clock), the pointer increments and the slave sends the byte at the new address. This repeats until the master NACKs.
- R9: When the master NACKs a read byte, the slave releases SDA and the pointer does not change.
- R10: A read that is not preceded by a pointer write starts at the pointer's current value.
- R11: A START or repeated START at any point restarts address reception. A STOP returns the slave to idle with SDA released.
- R12: dbg_data always shows the array location selected by dbg_addr, as combinational logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| dbg_addr | input | AW | Debug read address |
| dbg_data | output | 8 | Array content at dbg_addr |

## Verification
Each SCL edge takes three system clocks to affect sda_oe: two synchronizer flops plus the state register. The bench therefore changes SDA and samples the line only after a quarter SCL period of ten clocks has passed since the last SCL edge. A written byte reaches the array three clocks after the eighth SCL fall, and the debug port is combinational. For both reasons the bench reads array contents only after the STOP, when every write has long since landed. Acknowledges and read bits are sampled in the middle of the SCL high phase, well clear of the edges on which the slave changes its output.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // bus free or transfer finished
    S_ADDR,   // receiving address byte
    S_ACKA,   // acknowledging address
    S_WORD,   // receiving pointer byte
    S_ACKW,   // acknowledging pointer byte
    S_WDATA,  // receiving data byte
    S_ACKD,   // acknowledging data byte
    S_RDATA,  // transmitting data byte
    S_RACK,   // master acknowledge clock
    S_SKIP    // not addressed: wait for START or STOP
  } rp_state_e;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_ns,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  localparam int LEN = SYNC_STAGES + 1;

  logic [1:0]     rst_q;
  logic [LEN-1:0] scl_q, sda_q;
  logic           scl_now, scl_old, sda_now, sda_old;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[LEN-2:0], scl_i};
      sda_q <= {sda_q[LEN-2:0], sda_i};
    end
  end

  assign scl_now = scl_q[LEN-2];
  assign scl_old = scl_q[LEN-1];
  assign sda_now = sda_q[LEN-2];
  assign sda_old = sda_q[LEN-1];

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave #(
  parameter logic [6:0] SLAVE_ADDR = 7'h50,
  parameter int         DEPTH      = 8,
  localparam int        AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] dbg_addr,
  output logic [7:0]    dbg_data
);
  import i2c_rp_pkg::*;

  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic rst_ns, sda_s, scl_rise, scl_fall, start, stop;

  rp_state_e     st, st_n;
  logic [3:0]    cnt, cnt_n;
  logic [7:0]    sh, sh_n, tx, tx_n, rd_ptr;
  logic [AW-1:0] ptr, ptr_n, ptr_inc;
  logic          oe, oe_n, rw, rw_n, mack, mack_n, mem_we;

  i2c_rp_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_ns(rst_ns), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start(start), .stop(stop)
  );

  i2c_rp_regfile #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_ns), .we(mem_we), .waddr(ptr), .wdata(sh),
    .raddr_a(ptr), .rdata_a(rd_ptr), .raddr_b(dbg_addr), .rdata_b(dbg_data)
  );

  assign ptr_inc = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;

  // next-state logic
  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    tx_n   = tx;
    ptr_n  = ptr;
    oe_n   = oe;
    rw_n   = rw;
    mack_n = mack;
    mem_we = 1'b0;
    if (stop) begin
      st_n = S_IDLE;
      oe_n = 1'b0;
    end else if (start) begin
      st_n  = S_ADDR;
      cnt_n = 4'd0;
      oe_n  = 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WORD, S_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = 4'd0;
            if (st == S_ADDR) begin
              if (sh[7:1] == SLAVE_ADDR) begin
                oe_n = 1'b1;
                rw_n = sh[0];
                st_n = S_ACKA;
              end else begin
                st_n = S_SKIP;
              end
            end else if (st == S_WORD) begin
              ptr_n = sh[AW-1:0];
              oe_n  = 1'b1;
              st_n  = S_ACKW;
            end else begin
              mem_we = 1'b1;
              oe_n   = 1'b1;
              st_n   = S_ACKD;
            end
          end
        end
        S_ACKA: if (scl_fall) begin
          if (rw) begin
            st_n  = S_RDATA;
            tx_n  = rd_ptr;
            oe_n  = ~rd_ptr[7];
            cnt_n = 4'd0;
          end else begin
            oe_n = 1'b0;
            st_n = S_WORD;
          end
        end
        S_ACKW: if (scl_fall) begin
          oe_n = 1'b0;
          st_n = S_WDATA;
        end
        S_ACKD: if (scl_fall) begin
          oe_n  = 1'b0;
          ptr_n = ptr_inc;
          st_n  = S_WDATA;
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 4'd7) begin
            oe_n = 1'b0;
            st_n = S_RACK;
          end else begin
            tx_n  = {tx[6:0], 1'b0};
            oe_n  = ~tx[6];
            cnt_n = cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) ptr_n = ptr_inc;
          end else if (scl_fall) begin
            if (mack) begin
              st_n  = S_RDATA;
              tx_n  = rd_ptr;
              oe_n  = ~rd_ptr[7];
              cnt_n = 4'd0;
            end else begin
              st_n = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st   <= S_IDLE;
      cnt  <= 4'd0;
      sh   <= 8'h00;
      tx   <= 8'h00;
      ptr  <= '0;
      oe   <= 1'b0;
      rw   <= 1'b0;
      mack <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      tx   <= tx_n;
      ptr  <= ptr_n;
      oe   <= oe_n;
      rw   <= rw_n;
      mack <= mack_n;
    end
  end

  assign sda_oe = oe;

  // R3: a slave that is idle or not addressed never pulls SDA
  p_released_when_unaddressed_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == S_IDLE || st == S_SKIP) |-> !sda_oe);

  // R11: a START always restarts address reception with SDA released
  p_start_restarts_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    start |=> (st == S_ADDR && !sda_oe));

  // R9: a master NACK leaves the pointer untouched
  p_nack_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == S_RACK && scl_rise && sda_s) |=> $stable(ptr));

  // R5: a complete data byte is acknowledged on the following clock
  p_ack_after_data_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == S_WDATA && scl_fall && cnt == 4'd8 && !start && !stop) |=> sda_oe);

  // R6: pointer wraps from the last location to zero after a write ack
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == S_ACKD && scl_fall && ptr == PTR_LAST && !start && !stop) |=> (ptr == '0));
endmodule

// File: tb/test_i2c_regptr_slave.sv
module test_i2c_regptr_slave;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 10;
  localparam int         DEPTH      = 8;
  localparam int         AW         = $clog2(DEPTH);
  localparam logic [6:0] SA         = 7'h50;
  localparam logic [7:0] WHDR       = {SA, 1'b0};
  localparam logic [7:0] RHDR       = {SA, 1'b1};

  logic          clk, rst_n, scl, sda_m, sda_oe, sda_line;
  logic [AW-1:0] dbg_addr;
  logic [7:0]    dbg_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_mem [DEPTH];
  int         exp_ptr;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regptr_slave #(.SLAVE_ADDR(SA), .DEPTH(DEPTH)) i_i2c_regptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait();
      scl = 1'b1; qwait(); qwait();
      scl = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    ack = ~sda_line;
    qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qwait();
      scl = 1'b1; qwait();
      b[i] = sda_line;
      qwait();
      scl = 1'b0; qwait();
    end
    sda_m = ~give_ack; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic check_array(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      dbg_addr = AW'(a);
      @(negedge clk);
      chk(dbg_data == exp_mem[a], req, dbg_data, exp_mem[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit         ack;
    logic [7:0] b;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; dbg_addr = '0;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;
    exp_ptr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 and R12: reset state through the debug port
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    check_array("R1 R12 array cleared");

    // R3: wrong address gets no ack, and its data is ignored
    bus_start();
    wr_byte({SA ^ 7'h01, 1'b0}, ack);
    chk(ack == 1'b0, "R3 no ack for mismatch", ack, 0);
    wr_byte(8'h02, ack);
    wr_byte(8'h77, ack);
    chk(ack == 1'b0, "R3 data ignored no ack", ack, 0);
    bus_stop();
    check_array("R3 array untouched");

    // R2 R4 R5 R6: write the whole array starting at 5, wrapping
    bus_start();
    wr_byte(WHDR, ack);
    chk(ack == 1'b1, "R2 address ack", ack, 1);
    wr_byte(8'h05, ack);
    chk(ack == 1'b1, "R4 word ack", ack, 1);
    exp_ptr = 5;
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) & 8'hFF);
      wr_byte(d, ack);
      chk(ack == 1'b1, "R5 data ack", ack, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    bus_stop();
    check_array("R5 R6 written array");

    // R10 R9: current-address read twice with NACK; pointer holds
    for (int k = 0; k < 2; k++) begin
      bus_start();
      wr_byte(RHDR, ack);
      chk(ack == 1'b1, "R2 read header ack", ack, 1);
      rd_byte(1'b0, b);
      chk(b == exp_mem[exp_ptr], "R10 R9 current read", b, exp_mem[exp_ptr]);
      bus_stop();
    end

    // R4: word address taken modulo DEPTH
    bus_start();
    wr_byte(WHDR, ack);
    wr_byte(8'hF9, ack);
    wr_byte(8'hC3, ack);
    bus_stop();
    exp_mem[1] = 8'hC3;
    exp_ptr = 2;
    check_array("R4 modulo word address");

    // R7 R8 R6 R9 R10: random read at every address, three bytes each
    for (int a = 0; a < DEPTH; a++) begin
      bus_start();
      wr_byte(WHDR, ack);
      wr_byte(8'(a), ack);
      bus_rstart();
      wr_byte(RHDR, ack);
      chk(ack == 1'b1, "R7 read header ack", ack, 1);
      exp_ptr = a;
      for (int n = 0; n < 3; n++) begin
        rd_byte(n < 2, b);
        chk(b == exp_mem[exp_ptr], "R7 R8 R6 sequential read", b, exp_mem[exp_ptr]);
        if (n < 2) exp_ptr = (exp_ptr + 1) % DEPTH;
      end
      bus_stop();
      bus_start();
      wr_byte(RHDR, ack);
      rd_byte(1'b0, b);
      chk(b == exp_mem[exp_ptr], "R9 R10 pointer after NACK", b, exp_mem[exp_ptr]);
      bus_stop();
    end

    // R11: repeated START right after a write byte
    bus_start();
    wr_byte(WHDR, ack);
    wr_byte(8'h02, ack);
    wr_byte(8'h5A, ack);
    exp_mem[2] = 8'h5A;
    bus_rstart();
    wr_byte(RHDR, ack);
    chk(ack == 1'b1, "R11 ack after repeated start", ack, 1);
    rd_byte(1'b0, b);
    chk(b == exp_mem[3], "R11 read after repeated start", b, exp_mem[3]);
    bus_stop();
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);

    // R3: a mismatching read header is not acknowledged and sends nothing
    bus_start();
    wr_byte({SA ^ 7'h40, 1'b1}, ack);
    chk(ack == 1'b0, "R3 no ack read mismatch", ack, 0);
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R3 bus left released", b, 8'hFF);
    bus_stop();
    check_array("R12 final array");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule